// File: doc/BRIEF.md
# SPI Slave Byte Front End (Modes 0 and 3, with Hold)

This block sits between the four SPI pins of a serial memory-style slave and the command engine behind it. It oversamples chip select, serial clock, serial input and hold with a fast system clock. It turns the serial stream into whole received bytes and frame boundary pulses. It also shifts bytes supplied by the engine out on a serial output that has a separate drive enable for the pad. The transfer mode (clock idle low or idle high) is taken from the clock level seen when chip select falls, so the master may use either mode on any frame.

Received bytes leave on a valid-only stream. An SPI master cannot be stalled, so this side has no back-pressure: the engine must take `rx_data` in the single cycle that `rx_valid` is high. Output bytes enter through a one-entry buffer with a valid/ready handshake. `tx_ready` is high while a frame is open and the buffer is empty, and a byte is taken on any cycle where both `tx_valid` and `tx_ready` are high. For a byte to go out as byte N+1 of a frame, it must be accepted before the serial clock's falling edge that follows the eighth rising edge of byte N. If it is not, that byte goes out as all zeros. The first output byte of every frame is all zeros.

A hold input lets the master pause a frame without ending it. While the pause lasts, the output drive is off and clock and chip-select activity is ignored.

Top module: `spi_slave_fe`

## Requirements
- R1: Each group of eight SCK rising edges in a frame yields one `rx_valid` pulse, one cycle long. `rx_data` holds the eight sampled SI bits, the first sampled bit in bit 7.
- R2: Frames started with SCK high (mode 3) and with SCK low (mode 0) deliver the same bytes on both the input and the output side. In mode 3 the falling edge that comes before the first rising edge shifts nothing.
- R3: The output byte is sent most significant bit first, and a new bit appears after each SCK falling edge. Byte 0 of a frame is 0x00. Each later byte is the one most recently accepted into the buffer before the falling edge that starts it.
- R4: `tx_ready` is low in reset and while chip select is inactive. It is high in an open frame while the buffer is empty, and it goes low in the cycle after an accepted handshake.
- R5: `frame_start` pulses for one cycle after each chip-select fall, and `frame_end` pulses for one cycle after each chip-select rise. The two are never high together.
- R6: A chip-select fall restarts the bit count, so bits of an incomplete byte from the previous frame are dropped.
- R7: While chip select is high, `spi_so_oe` is low and SCK edges produce no received bytes.
- R8: Hold low, entered while SCK is low, turns the output drive off and ignores SCK edges and chip-select changes. Releasing hold while SCK is low resumes the frame at the bit where it stopped.
- R9: A hold change made while SCK is high is not acted on. The drive stays on and the byte in progress completes correctly.
- R10: `spi_so_oe` is high only while `read_phase` is high. A frame with `read_phase` low still receives bytes.
- R11: If SCK stops for any length of time in the middle of a byte, no state is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Drive enable for the serial output pad |
| read_phase | input | 1 | Engine permits output drive |
| rx_valid | output | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Engine offers an output byte |
| tx_ready | output | 1 | Output buffer can take a byte |
| tx_data | input | 8 | Output byte offered |
| frame_start | output | 1 | One-cycle pulse after chip select falls |
| frame_end | output | 1 | One-cycle pulse after chip select rises |

## Verification
A bit counter that is off by one shows up within the same byte: `rx_data` is rotated and the next `rx_valid` comes one SCK edge early or late. A stale mode or hold state shows up within one SCK half-period. The output byte is then shifted by one bit, or `spi_so_oe` stays low after release. A wrong buffer flag either repeats a byte or inserts 0x00 at the next byte boundary, and the engine sees `tx_ready` stuck in one state.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic si;
    logic hold_n;
  } spi_pins_t;
  localparam int SPI_PIN_N = 4;
  localparam spi_pins_t SPI_PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, si: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_fe_ctl.sv
module spi_fe_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sck_s,
  input  logic hold_s,
  output logic held,
  output logic frame_act,
  output logic ev_start,
  output logic ev_end,
  output logic ev_rise,
  output logic ev_shift
);
  logic cs_eff, sck_q, mode_hi, seen_rise, active, ev_fall;

  assign active   = ~cs_eff & ~held & ~cs_s;
  assign ev_start = ~held & cs_eff & ~cs_s;
  assign ev_end   = ~held & ~cs_eff & cs_s;
  assign ev_rise  = active & sck_s & ~sck_q;
  assign ev_fall  = active & ~sck_s & sck_q;
  assign ev_shift = ev_fall & (seen_rise | ~mode_hi);
  assign frame_act = ~cs_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      cs_eff    <= 1'b1;
      sck_q     <= 1'b0;
      mode_hi   <= 1'b0;
      seen_rise <= 1'b0;
    end else begin
      sck_q <= sck_s;
      if (!sck_s) held <= ~hold_s;
      if (!held) cs_eff <= cs_s;
      if (ev_start) begin
        mode_hi   <= sck_s;
        seen_rise <= 1'b0;
      end else if (ev_rise) begin
        seen_rise <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise,
  input  logic              si,
  output logic              at_bound,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-2:0] shreg;

  assign at_bound = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (clr) begin
      cnt      <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        shreg <= {shreg[DATA_W-3:0], si};
        cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) begin
          rx_valid <= 1'b1;
          rx_data  <= {shreg, si};
        end
      end
    end
  end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic              at_bound,
  input  logic              frame_act,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              so_bit
);
  logic [DATA_W-1:0] hold_buf, shreg;
  logic              full;

  assign tx_ready = ~full & frame_act;
  assign so_bit   = shreg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_buf <= '0;
      shreg    <= '0;
      full     <= 1'b0;
    end else if (clr) begin
      shreg <= '0;
      full  <= 1'b0;
    end else begin
      if (shift) begin
        if (at_bound) shreg <= full ? hold_buf : '0;
        else          shreg <= {shreg[DATA_W-2:0], 1'b0};
      end
      if (tx_valid && tx_ready) begin
        hold_buf <= tx_data;
        full     <= 1'b1;
      end else if (shift && at_bound) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_slave_fe.sv
module spi_slave_fe #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic              read_phase,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              frame_start,
  output logic              frame_end
);
  import spi_fe_pkg::*;

  spi_pins_t pins_raw, pins_s;
  logic held, frame_act, ev_start, ev_end, ev_rise, ev_shift, at_bound;

  assign pins_raw = '{cs_n: spi_cs_n, sck: spi_sck, si: spi_si, hold_n: spi_hold_n};

  spi_fe_sync #(.WIDTH(SPI_PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(SPI_PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  spi_fe_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .cs_s(pins_s.cs_n), .sck_s(pins_s.sck), .hold_s(pins_s.hold_n),
    .held(held), .frame_act(frame_act),
    .ev_start(ev_start), .ev_end(ev_end), .ev_rise(ev_rise), .ev_shift(ev_shift)
  );

  spi_fe_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(ev_start), .rise(ev_rise), .si(pins_s.si),
    .at_bound(at_bound), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  spi_fe_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(ev_start), .shift(ev_shift), .at_bound(at_bound),
    .frame_act(frame_act), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .so_bit(spi_so)
  );

  assign spi_so_oe = frame_act & ~held & read_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      frame_start <= ev_start;
      frame_end   <= ev_end;
    end
  end
endmodule

// File: rtl/spi_slave_fe_chk.sv
module spi_slave_fe_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic frame_start,
  input logic frame_end,
  input logic tx_valid,
  input logic tx_ready,
  input logic spi_so_oe,
  input logic held
);
  assert_rx_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  assert_start_end_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !frame_end);
  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  assert_end_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !spi_so_oe);
  assert_hold_no_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !rx_valid);
endmodule

bind spi_slave_fe spi_slave_fe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .frame_start(frame_start),
  .frame_end(frame_end), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .spi_so_oe(spi_so_oe), .held(held)
);

// File: tb/spi_slave_fe_tb.sv
`timescale 1ns/1ps
module spi_slave_fe_tb_top;
  localparam int H = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_si = 1'b0, spi_hold_n = 1'b1;
  logic read_phase = 1'b1;
  logic spi_so, spi_so_oe, rx_valid, tx_ready, frame_start, frame_end;
  logic tx_valid = 1'b0;
  logic [7:0] rx_data, tx_data = 8'h00;

  always #4 clk = ~clk;

  spi_slave_fe dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_si(spi_si),
    .spi_hold_n(spi_hold_n), .spi_so(spi_so), .spi_so_oe(spi_so_oe), .read_phase(read_phase),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .frame_start(frame_start), .frame_end(frame_end)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rx_cnt = 0, fs_cnt = 0, fe_cnt = 0, idx = 0;
  logic rdy_prev = 1'b0;
  logic m3 = 1'b0;
  logic [7:0] tx_q [16];
  logic [7:0] rx_buf [256];
  logic [7:0] sent [8];

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // engine model and monitors
  always @(negedge clk) begin
    cyc++;
    if (rx_valid) begin rx_buf[rx_cnt % 256] = rx_data; rx_cnt++; end
    if (frame_end) fe_cnt++;
    if (frame_start) begin fs_cnt++; idx = 0; end
    else if (tx_valid && rdy_prev && idx < 15) idx++;
    tx_valid = 1'b1;
    tx_data  = tx_q[idx];
    rdy_prev = tx_ready;
    if (cyc == 180000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 180000);
      report();
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_bit(input logic b, output logic so, output logic oe);
    if (m3) begin
      spi_sck = 1'b0; spi_si = b; wt(H); so = spi_so; oe = spi_so_oe; spi_sck = 1'b1; wt(H);
    end else begin
      spi_si = b; wt(H); so = spi_so; oe = spi_so_oe; spi_sck = 1'b1; wt(H); spi_sck = 1'b0;
    end
  endtask

  task automatic do_byte(input logic [7:0] d, input int pause, output logic [7:0] q, output logic oe_all);
    logic s, o;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      if (i == pause) wt(300);
      do_bit(d[i], s, o);
      q[i] = s;
      oe_all &= o;
    end
  endtask

  task automatic cs_start;
    spi_sck = m3; wt(6); spi_cs_n = 1'b0; wt(8);
  endtask

  task automatic cs_stop;
    wt(H); spi_cs_n = 1'b1; wt(12);
  endtask

  task automatic run_frame(input logic mode, input int n, input logic rd, input int pause);
    int base, fs0, fe0;
    logic [7:0] got;
    logic oe;
    string rq;
    m3 = mode; read_phase = rd;
    for (int k = 0; k < 16; k++) tx_q[k] = 8'($urandom);
    for (int k = 0; k < n; k++) sent[k] = 8'($urandom);
    base = rx_cnt; fs0 = fs_cnt; fe0 = fe_cnt;
    rq = mode ? "R2" : "R1";
    cs_start();
    for (int k = 0; k < n; k++) begin
      do_byte(sent[k], (k == 0) ? pause : -1, got, oe);
      if (rd) chk("R3 output byte", int'(got), (k == 0) ? 0 : int'(tx_q[k-1]));
      if (mode && rd) chk("R2 mode 3 output byte", int'(got), (k == 0) ? 0 : int'(tx_q[k-1]));
      chk("R10 drive enable follows read_phase", int'(oe), int'(rd));
    end
    cs_stop();
    chk({rq, " byte count"}, rx_cnt - base, n);
    for (int k = 0; k < n; k++) chk({rq, " received byte"}, int'(rx_buf[(base + k) % 256]), int'(sent[k]));
    chk("R5 frame_start count", fs_cnt - fs0, 1);
    chk("R5 frame_end count", fe_cnt - fe0, 1);
  endtask

  initial begin : main
    logic [7:0] got;
    logic s, o, oe;
    int base, rc, fe;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 16; k++) tx_q[k] = 8'h00;
    wt(4);
    // reset state
    chk("R7 reset drive enable", int'(spi_so_oe), 0);
    chk("R1 reset rx_valid", int'(rx_valid), 0);
    chk("R4 reset tx_ready", int'(tx_ready), 0);
    chk("R5 reset frame_start", int'(frame_start), 0);
    rst_n = 1'b1;
    wt(6);

    // R7: SCK activity with chip select high
    base = rx_cnt;
    repeat (16) begin spi_si = 1'($urandom); spi_sck = 1'b1; wt(H); spi_sck = 1'b0; wt(H); end
    chk("R7 no bytes while deselected", rx_cnt - base, 0);
    chk("R7 no drive while deselected", int'(spi_so_oe), 0);
    chk("R4 tx_ready low while deselected", int'(tx_ready), 0);

    // directed mode checks
    run_frame(1'b0, 3, 1'b1, -1);
    run_frame(1'b1, 3, 1'b1, -1);
    // R10: no drive with read_phase low
    run_frame(1'b0, 2, 1'b0, -1);
    // R11: long stop of SCK mid-byte in both modes
    run_frame(1'b1, 2, 1'b1, 3);
    chk("R11 stopped clock frame done", fe_cnt > 0, 1);
    run_frame(1'b0, 2, 1'b1, 5);

    // R6: partial byte dropped at next frame
    m3 = 1'b0; read_phase = 1'b1; base = rx_cnt;
    cs_start();
    do_bit(1'b1, s, o); do_bit(1'b0, s, o); do_bit(1'b1, s, o);
    cs_stop();
    cs_start();
    do_byte(8'h81, -1, got, oe);
    cs_stop();
    chk("R6 only one byte after partial frame", rx_cnt - base, 1);
    chk("R6 byte aligned after restart", int'(rx_buf[base % 256]), 8'h81);

    // R8 / R9 hold handling, mode 0
    m3 = 1'b0; read_phase = 1'b1; base = rx_cnt;
    tx_q[0] = 8'hA5; tx_q[1] = 8'h3E;
    cs_start();
    chk("R4 tx_ready low once buffer filled", int'(tx_ready), 0);
    do_byte(8'h3C, -1, got, oe);
    chk("R3 first byte zero", int'(got), 0);
    for (int i = 7; i >= 4; i--) begin do_bit(1'(8'hC3 >> i), s, o); got[i] = s; end
    spi_hold_n = 1'b0; wt(6);
    chk("R8 drive off while held", int'(spi_so_oe), 0);
    rc = rx_cnt; fe = fe_cnt;
    repeat (3) begin spi_sck = 1'b1; wt(H); spi_sck = 1'b0; wt(H); end
    spi_cs_n = 1'b1; wt(8); spi_cs_n = 1'b0; wt(8);
    chk("R8 SCK ignored while held", rx_cnt - rc, 0);
    chk("R8 chip select ignored while held", fe_cnt - fe, 0);
    chk("R8 drive still off", int'(spi_so_oe), 0);
    spi_hold_n = 1'b1; wt(6);
    chk("R8 drive back after release", int'(spi_so_oe), 1);
    for (int i = 3; i >= 0; i--) begin do_bit(1'(8'hC3 >> i), s, o); got[i] = s; end
    chk("R8 output byte across hold", int'(got), 8'hA5);
    // R9: hold pulse while SCK high
    spi_si = 1'b0; wt(H); got[7] = spi_so; spi_sck = 1'b1; wt(2);
    spi_hold_n = 1'b0; wt(4);
    chk("R9 hold ignored while SCK high", int'(spi_so_oe), 1);
    spi_hold_n = 1'b1; wt(2); spi_sck = 1'b0;
    for (int i = 6; i >= 0; i--) begin do_bit(1'(8'h5B >> i), s, o); got[i] = s; end
    chk("R9 output byte intact", int'(got), 8'h3E);
    cs_stop();
    chk("R8 bytes received", rx_cnt - base, 3);
    chk("R8 byte across hold", int'(rx_buf[(base + 1) % 256]), 8'hC3);
    chk("R9 byte intact", int'(rx_buf[(base + 2) % 256]), 8'h5B);

    // constrained random frames
    for (int f = 0; f < 24; f++)
      run_frame(1'($urandom), 1 + int'($urandom % 6), ($urandom % 5) != 0, -1);

    report();
    $finish;
  end
endmodule